// File: doc/BRIEF.md
# DMA Register File and Command Decoder

This block is the processor-facing programming side of a four-channel DMA controller. A host reaches it through a 4-bit register address, an 8-bit write bus and an 8-bit read bus, qualified by a chip select and by the bus-grant signal. Access is accepted only while chip select is high and the grant is low. Each channel holds a 16-bit address and a 16-bit word count, in a base copy and a current copy. Both copies are loaded together, one byte at a time, and a shared byte pointer picks the low or the high half. The higher register codes carry the command register, the mode registers, the single-bit and whole-set mask and request writes, the status and temporary reads, and three commands that use no data: clear the byte pointer, master clear, and unmask all.

The transfer engine sits beside the block. It reports end-of-process per channel, reports live hardware requests, writes back the current address and count it has advanced, and loads the temporary byte during memory-to-memory moves. On end-of-process the block either masks the channel or reloads the current copies from the base copies, depending on the autoinitialize bit in the channel's mode.

A small access state machine turns strobe levels into single events. It has three states. ACC_IDLE waits for a strobe. ACC_WRITE is held while the write strobe stays high. ACC_READ is held while the read strobe stays high and drives read data. The transitions are: ACC_IDLE to ACC_WRITE on a high write strobe, where the write fires once on entry if access is allowed; ACC_IDLE to ACC_READ on a high read strobe with the write strobe low, where the address and the allow flag are latched; ACC_WRITE to ACC_IDLE when the write strobe drops; ACC_READ to ACC_IDLE when the read strobe drops, where the read-completion side effects fire.

Top module: `dma_rf`

## Requirements
- R1: After reset, mask_o is 4'hF, cmd_o, swreq_o and the status terminal flags are zero, the temporary byte reads as zero, and the byte pointer selects the low byte.
- R2: With reg_addr[3]=0, reg_addr[2:1] is the channel and reg_addr[0] picks address (0) or word count (1). Each channel-register read or write uses bits 7:0 when the pointer is low and bits 15:8 when it is high, and toggles the pointer when it completes.
- R3: A channel-register write loads the byte into the base and the current copy together. A read returns the current copy, including values written back by the engine through upd_en, upd_chan, upd_addr and upd_count.
- R4: A write to code 4'hC clears the byte pointer, so the next channel access uses the low byte.
- R5: A write to code 4'h8 loads cmd_o from wdata, and ctrl_off follows command bit 2.
- R6: A write to code 4'hB stores wdata[7:2] as the mode of the channel in wdata[1:0]. Mode bit 2 (wdata bit 4) is autoinitialize.
- R7: Code 4'h9 sets or clears one request bit, and code 4'hA sets or clears one mask bit. In both, wdata[1:0] is the channel and wdata[2] is the new value.
- R8: A write to code 4'hE clears all mask bits. A write to code 4'hF loads all four mask bits from wdata[3:0].
- R9: A read of code 4'h8 returns {req_live | swreq_o, terminal flags}. The flags in bits 3:0 are cleared when the read strobe ends. An end-of-process in the same cycle wins over the clear.
- R10: eop_in[i] sets terminal flag i and clears request bit i. When channel i is not autoinitialize, it also sets mask bit i.
- R11: eop_in[i] on an autoinitialize channel copies base to current for both address and count, and leaves mask bit i unchanged.
- R12: A read of code 4'hD returns the temporary byte loaded by tmp_load. A write to code 4'hD acts like reset on the command, status, request, temporary, pointer and mask state, and keeps the mode and channel registers.
- R13: A strobe seen while cpu_sel is low or bus_grant is high changes no register and does not move the pointer. Such a read returns zero, and rdata is zero whenever no read is in progress.
- R14: A write strobe held high for several cycles acts only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| cpu_sel | input | 1 | Chip select, active high |
| bus_grant | input | 1 | Bus granted to DMA; blocks host access when high |
| reg_addr | input | 4 | Register address |
| wr_stb | input | 1 | Write strobe, active high |
| rd_stb | input | 1 | Read strobe, active high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero outside an accepted read |
| eop_in | input | 4 | Per-channel end-of-process pulse from the engine |
| req_live | input | 4 | Live hardware requests, shown in status bits 7:4 |
| tmp_load | input | 1 | Load the temporary byte |
| tmp_din | input | 8 | Temporary byte from the engine |
| upd_en | input | 1 | Engine write-back of a channel's current registers |
| upd_chan | input | 2 | Channel for the write-back |
| upd_addr | input | 16 | Current address write-back value |
| upd_count | input | 16 | Current word count write-back value |
| cur_addr_o | output | 64 | Current addresses, channel i at bits 16i+15:16i |
| cur_count_o | output | 64 | Current word counts, same packing |
| mode_o | output | 24 | Mode fields, channel i at bits 6i+5:6i |
| mask_o | output | 4 | Mask bits |
| swreq_o | output | 4 | Software request bits |
| cmd_o | output | 8 | Command register |
| ctrl_off | output | 1 | Controller disabled (command bit 2) |

## Verification
The bench follows the byte pointer across mixed reads, writes, the pointer-clear command and master clear. A design that toggled on a blocked access, on a non-channel code or more than once for a held strobe would put bytes into the wrong half, and the 16-bit value read back would show it. After an engine write-back, reads must return the current copy and not the base. On end-of-process the bench compares an autoinitialize channel with a plain one: a design that masked the autoinitialize channel, or did not restore both base values, fails the mask and register checks. The status flags are read twice in a row, so a design that never cleared them on read, or cleared them when the read began, gives the wrong second value.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
    localparam int DW            = 8;
    localparam int RW            = 2 * DW;
    localparam int NCH           = 4;
    localparam int CHW           = $clog2(NCH);
    localparam int AW            = 4;
    localparam int MODE_W        = DW - CHW;
    localparam int MODE_AUTO_BIT = 2;
    localparam int CMD_OFF_BIT   = 2;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_state_e;

    typedef enum logic [2:0] {
        SW_STAT_CMD = 3'd0,
        SW_REQ1     = 3'd1,
        SW_MASK1    = 3'd2,
        SW_MODE     = 3'd3,
        SW_PTRCLR   = 3'd4,
        SW_TMP_MCLR = 3'd5,
        SW_UNMASK   = 3'd6,
        SW_MASKALL  = 3'd7
    } sw_cmd_e;
endpackage

// File: rtl/dma_rf_acc_fsm.sv
module dma_rf_acc_fsm
    import dma_rf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  logic          rd_stb,
    input  logic          allow,
    input  logic [AW-1:0] addr,
    output logic          wr_fire,
    output logic          rd_live,
    output logic          rd_done,
    output logic [AW-1:0] rd_addr
);
    acc_state_e    state_q, state_n;
    logic          rd_ok_q;
    logic [AW-1:0] rd_addr_q;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ACC_IDLE: begin
                if (wr_stb)      state_n = ACC_WRITE;
                else if (rd_stb) state_n = ACC_READ;
            end
            ACC_WRITE: if (!wr_stb) state_n = ACC_IDLE;
            ACC_READ:  if (!rd_stb) state_n = ACC_IDLE;
            default:   state_n = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state_q <= ACC_IDLE;
        else     state_q <= state_n;
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            rd_ok_q   <= 1'b0;
            rd_addr_q <= '0;
        end else if (state_q == ACC_IDLE && !wr_stb && rd_stb) begin
            rd_ok_q   <= allow;
            rd_addr_q <= addr;
        end
    end

    always_comb begin
        wr_fire = (state_q == ACC_IDLE) && wr_stb && allow;
        rd_live = (state_q == ACC_READ) && rd_ok_q;
        rd_done = (state_q == ACC_READ) && !rd_stb && rd_ok_q;
        rd_addr = rd_addr_q;
    end
endmodule

// File: rtl/dma_rf_chan.sv
module dma_rf_chan
    import dma_rf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_cnt,
    input  logic          wr_hi,
    input  logic [DW-1:0] wr_byte,
    input  logic          reload,
    input  logic          upd_en,
    input  logic [RW-1:0] upd_addr,
    input  logic [RW-1:0] upd_count,
    output logic [RW-1:0] cur_addr,
    output logic [RW-1:0] cur_count
);
    logic [RW-1:0] base_a_q, base_c_q, cur_a_q, cur_c_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            base_a_q <= '0;
            cur_a_q  <= '0;
        end else if (wr_en && !wr_cnt) begin
            if (wr_hi) begin
                base_a_q[RW-1:DW] <= wr_byte;
                cur_a_q[RW-1:DW]  <= wr_byte;
            end else begin
                base_a_q[DW-1:0]  <= wr_byte;
                cur_a_q[DW-1:0]   <= wr_byte;
            end
        end else if (reload) begin
            cur_a_q <= base_a_q;
        end else if (upd_en) begin
            cur_a_q <= upd_addr;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            base_c_q <= '0;
            cur_c_q  <= '0;
        end else if (wr_en && wr_cnt) begin
            if (wr_hi) begin
                base_c_q[RW-1:DW] <= wr_byte;
                cur_c_q[RW-1:DW]  <= wr_byte;
            end else begin
                base_c_q[DW-1:0]  <= wr_byte;
                cur_c_q[DW-1:0]   <= wr_byte;
            end
        end else if (reload) begin
            cur_c_q <= base_c_q;
        end else if (upd_en) begin
            cur_c_q <= upd_count;
        end
    end

    assign cur_addr  = cur_a_q;
    assign cur_count = cur_c_q;
endmodule

// File: rtl/dma_rf.sv
module dma_rf
    import dma_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_sel,
    input  logic              bus_grant,
    input  logic [AW-1:0]     reg_addr,
    input  logic              wr_stb,
    input  logic              rd_stb,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [NCH-1:0]    eop_in,
    input  logic [NCH-1:0]    req_live,
    input  logic              tmp_load,
    input  logic [DW-1:0]     tmp_din,
    input  logic              upd_en,
    input  logic [CHW-1:0]    upd_chan,
    input  logic [RW-1:0]     upd_addr,
    input  logic [RW-1:0]     upd_count,
    output logic [NCH*RW-1:0] cur_addr_o,
    output logic [NCH*RW-1:0] cur_count_o,
    output logic [NCH*MODE_W-1:0] mode_o,
    output logic [NCH-1:0]    mask_o,
    output logic [NCH-1:0]    swreq_o,
    output logic [DW-1:0]     cmd_o,
    output logic              ctrl_off
);
    logic          wr_fire, rd_live, rd_done;
    logic [AW-1:0] rd_addr;

    dma_rf_acc_fsm u_acc (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .allow   (cpu_sel && !bus_grant),
        .addr    (reg_addr),
        .wr_fire (wr_fire),
        .rd_live (rd_live),
        .rd_done (rd_done),
        .rd_addr (rd_addr)
    );

    logic [DW-1:0]     cmd_q, cmd_n;
    logic [NCH-1:0]    tc_q, tc_n, req_q, req_n, mask_q, mask_n;
    logic [DW-1:0]     tmp_q, tmp_n;
    logic              ptr_q, ptr_n;
    logic [MODE_W-1:0] mode_q [NCH];
    logic [RW-1:0]     cur_a [NCH];
    logic [RW-1:0]     cur_c [NCH];

    logic    chan_wr, chan_rd_done, cmd_wr;
    sw_cmd_e wcode;

    assign chan_wr      = wr_fire && !reg_addr[AW-1];
    assign chan_rd_done = rd_done && !rd_addr[AW-1];
    assign cmd_wr       = wr_fire && reg_addr[AW-1];
    assign wcode        = sw_cmd_e'(reg_addr[AW-2:0]);

    // channel register banks
    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dma_rf_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (chan_wr && (reg_addr[AW-2:1] == CHW'(i))),
            .wr_cnt    (reg_addr[0]),
            .wr_hi     (ptr_q),
            .wr_byte   (wdata),
            .reload    (eop_in[i] && mode_q[i][MODE_AUTO_BIT]),
            .upd_en    (upd_en && (upd_chan == CHW'(i))),
            .upd_addr  (upd_addr),
            .upd_count (upd_count),
            .cur_addr  (cur_a[i]),
            .cur_count (cur_c[i])
        );
        assign cur_addr_o[i*RW +: RW]      = cur_a[i];
        assign cur_count_o[i*RW +: RW]     = cur_c[i];
        assign mode_o[i*MODE_W +: MODE_W]  = mode_q[i];
    end

    // command decode and end-of-process handling
    always_comb begin
        cmd_n  = cmd_q;
        tc_n   = tc_q;
        req_n  = req_q;
        mask_n = mask_q;
        tmp_n  = tmp_q;
        ptr_n  = ptr_q;
        if (tmp_load) tmp_n = tmp_din;
        if (chan_wr || chan_rd_done) ptr_n = !ptr_q;
        if (rd_done && rd_addr[AW-1] && rd_addr[AW-2:0] == SW_STAT_CMD) tc_n = '0;
        if (cmd_wr) begin
            unique case (wcode)
                SW_STAT_CMD: cmd_n = wdata;
                SW_REQ1:     req_n[wdata[CHW-1:0]]  = wdata[CHW];
                SW_MASK1:    mask_n[wdata[CHW-1:0]] = wdata[CHW];
                SW_MODE:     ;
                SW_PTRCLR:   ptr_n = 1'b0;
                SW_TMP_MCLR: begin
                    cmd_n  = '0;
                    tc_n   = '0;
                    req_n  = '0;
                    tmp_n  = '0;
                    ptr_n  = 1'b0;
                    mask_n = '1;
                end
                SW_UNMASK:   mask_n = '0;
                SW_MASKALL:  mask_n = wdata[NCH-1:0];
            endcase
        end
        for (int i = 0; i < NCH; i++) begin
            if (eop_in[i]) begin
                tc_n[i]  = 1'b1;
                req_n[i] = 1'b0;
                if (!mode_q[i][MODE_AUTO_BIT]) mask_n[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cmd_q  <= '0;
            tc_q   <= '0;
            req_q  <= '0;
            mask_q <= '1;
            tmp_q  <= '0;
            ptr_q  <= 1'b0;
        end else begin
            cmd_q  <= cmd_n;
            tc_q   <= tc_n;
            req_q  <= req_n;
            mask_q <= mask_n;
            tmp_q  <= tmp_n;
            ptr_q  <= ptr_n;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) mode_q[i] <= '0;
        end else if (cmd_wr && wcode == SW_MODE) begin
            mode_q[wdata[CHW-1:0]] <= wdata[DW-1:CHW];
        end
    end

    // read data path
    logic [RW-1:0] rd_word;
    always_comb begin
        rd_word = rd_addr[0] ? cur_c[rd_addr[AW-2:1]] : cur_a[rd_addr[AW-2:1]];
        rdata   = '0;
        if (rd_live) begin
            if (!rd_addr[AW-1]) begin
                rdata = ptr_q ? rd_word[RW-1:DW] : rd_word[DW-1:0];
            end else if (rd_addr[AW-2:0] == SW_STAT_CMD) begin
                rdata = {req_live | req_q, tc_q};
            end else if (rd_addr[AW-2:0] == SW_TMP_MCLR) begin
                rdata = tmp_q;
            end
        end
    end

    assign mask_o   = mask_q;
    assign swreq_o  = req_q;
    assign cmd_o    = cmd_q;
    assign ctrl_off = cmd_q[CMD_OFF_BIT];
endmodule

// File: rtl/dma_rf_sva.sv
module dma_rf_sva
    import dma_rf_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    cpu_sel,
    input logic                    bus_grant,
    input logic                    wr_stb,
    input logic                    rd_stb,
    input logic [DW-1:0]           rdata,
    input logic [NCH-1:0]          eop_in,
    input logic [NCH*MODE_W-1:0]   mode_o,
    input logic [NCH-1:0]          mask_o,
    input logic [NCH-1:0]          swreq_o,
    input logic [DW-1:0]           cmd_o
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_o == '1 && cmd_o == '0 && swreq_o == '0));

    assert_grant_freeze_R13: assert property (@(posedge clk) disable iff (rst)
        bus_grant |=> ($stable(cmd_o) && $stable(mode_o)));

    assert_rdata_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        !$past(rd_stb) |-> rdata == '0);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assert_mask_on_eop_R10: assert property (@(posedge clk) disable iff (rst)
            (eop_in[i] && !mode_o[i*MODE_W + MODE_AUTO_BIT]) |=> mask_o[i]);

        assert_req_drop_on_eop_R10: assert property (@(posedge clk) disable iff (rst)
            eop_in[i] |=> !swreq_o[i]);

        assert_auto_mask_kept_R11: assert property (@(posedge clk) disable iff (rst)
            (eop_in[i] && mode_o[i*MODE_W + MODE_AUTO_BIT] && !(wr_stb && cpu_sel && !bus_grant))
            |=> (mask_o[i] == $past(mask_o[i])));
    end
endmodule

bind dma_rf dma_rf_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .cpu_sel   (cpu_sel),
    .bus_grant (bus_grant),
    .wr_stb    (wr_stb),
    .rd_stb    (rd_stb),
    .rdata     (rdata),
    .eop_in    (eop_in),
    .mode_o    (mode_o),
    .mask_o    (mask_o),
    .swreq_o   (swreq_o),
    .cmd_o     (cmd_o)
);

// File: tb/dma_rf_tb.sv
`timescale 1ns/1ps
module dma_rf_tb;
    import dma_rf_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cpu_sel = 1'b1, bus_grant = 1'b0;
    logic [AW-1:0]     reg_addr = '0;
    logic              wr_stb = 1'b0, rd_stb = 1'b0;
    logic [DW-1:0]     wdata = '0, rdata;
    logic [NCH-1:0]    eop_in = '0, req_live = '0;
    logic              tmp_load = 1'b0;
    logic [DW-1:0]     tmp_din = '0;
    logic              upd_en = 1'b0;
    logic [CHW-1:0]    upd_chan = '0;
    logic [RW-1:0]     upd_addr = '0, upd_count = '0;
    logic [NCH*RW-1:0] cur_addr_o, cur_count_o;
    logic [NCH*MODE_W-1:0] mode_o;
    logic [NCH-1:0]    mask_o, swreq_o;
    logic [DW-1:0]     cmd_o;
    logic              ctrl_off;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    dma_rf u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; wdata = d; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic cpu_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; rd_stb = 1'b1;
        @(negedge clk); d = rdata; rd_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_eop(input int ch);
        @(negedge clk); eop_in[ch] = 1'b1;
        @(negedge clk); eop_in = '0;
    endtask

    function automatic logic [15:0] caddr(input int ch);
        return cur_addr_o[ch*RW +: RW];
    endfunction
    function automatic logic [15:0] ccnt(input int ch);
        return cur_count_o[ch*RW +: RW];
    endfunction
    function automatic logic [5:0] cmode(input int ch);
        return mode_o[ch*MODE_W +: MODE_W];
    endfunction

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 mask", 32'(mask_o), 32'hF);
        chk("R1 cmd", 32'(cmd_o), 32'h0);
        chk("R1 swreq", 32'(swreq_o), 32'h0);
        cpu_read(4'h8, d); chk("R1 status", 32'(d), 32'h0);
        cpu_read(4'hD, d); chk("R1 temp", 32'(d), 32'h0);
    endtask

    task automatic t_chan_rw();
        logic [7:0] d;
        cpu_write(4'h4, 8'h34); cpu_write(4'h4, 8'h12);
        chk("R2 ch2 addr", 32'(caddr(2)), 32'h1234);
        cpu_write(4'h5, 8'h05); cpu_write(4'h5, 8'h00);
        chk("R2 ch2 count", 32'(ccnt(2)), 32'h0005);
        chk("R2 ch1 untouched", 32'(caddr(1)), 32'h0);
        cpu_read(4'h4, d); chk("R2 read low", 32'(d), 32'h34);
        cpu_read(4'h4, d); chk("R2 read high", 32'(d), 32'h12);
    endtask

    task automatic t_engine_update();
        logic [7:0] d;
        @(negedge clk); upd_en = 1'b1; upd_chan = 2'd2; upd_addr = 16'h1300; upd_count = 16'h0002;
        @(negedge clk); upd_en = 1'b0;
        cpu_read(4'h4, d); chk("R3 current low", 32'(d), 32'h00);
        cpu_read(4'h4, d); chk("R3 current high", 32'(d), 32'h13);
        cpu_read(4'h5, d); chk("R3 count low", 32'(d), 32'h02);
        cpu_read(4'h5, d);
    endtask

    task automatic t_ptr_clear();
        logic [7:0] d;
        cpu_write(4'h4, 8'hAA);
        chk("R3 write hits current", 32'(caddr(2)), 32'h13AA);
        cpu_write(4'hC, 8'h00);
        cpu_read(4'h4, d); chk("R4 low after clear", 32'(d), 32'hAA);
        cpu_read(4'h4, d); chk("R4 then high", 32'(d), 32'h13);
    endtask

    task automatic t_command();
        cpu_write(4'h8, 8'h04);
        chk("R5 cmd", 32'(cmd_o), 32'h04);
        chk("R5 disable", 32'(ctrl_off), 32'h1);
        cpu_write(4'h8, 8'h00);
        chk("R5 enable", 32'(ctrl_off), 32'h0);
    endtask

    task automatic t_mode();
        cpu_write(4'hB, 8'h56);
        chk("R6 ch2 mode", 32'(cmode(2)), 32'h15);
        chk("R6 ch0 mode", 32'(cmode(0)), 32'h00);
    endtask

    task automatic t_req_mask();
        logic [7:0] d;
        cpu_write(4'h9, 8'h05);
        chk("R7 req set", 32'(swreq_o), 32'h2);
        cpu_read(4'h8, d); chk("R9 status req", 32'(d), 32'h20);
        @(negedge clk); req_live = 4'b1000;
        cpu_read(4'h8, d); chk("R9 status live", 32'(d), 32'hA0);
        @(negedge clk); req_live = '0;
        cpu_write(4'h9, 8'h01);
        chk("R7 req clear", 32'(swreq_o), 32'h0);
        cpu_write(4'hE, 8'h00);
        chk("R8 unmask all", 32'(mask_o), 32'h0);
        cpu_write(4'hA, 8'h07);
        chk("R7 mask set", 32'(mask_o), 32'h8);
        cpu_write(4'hA, 8'h03);
        chk("R7 mask clear", 32'(mask_o), 32'h0);
        cpu_write(4'hF, 8'h05);
        chk("R8 mask all", 32'(mask_o), 32'h5);
    endtask

    task automatic t_eop_plain();
        logic [7:0] d;
        cpu_write(4'hE, 8'h00);
        cpu_write(4'h9, 8'h05);
        pulse_eop(1);
        @(negedge clk);
        chk("R10 mask set", 32'(mask_o), 32'h2);
        chk("R10 req cleared", 32'(swreq_o), 32'h0);
        cpu_read(4'h8, d); chk("R9 tc flag", 32'(d), 32'h02);
        cpu_read(4'h8, d); chk("R9 cleared on read", 32'(d), 32'h00);
    endtask

    task automatic t_eop_auto();
        logic [7:0] d;
        cpu_write(4'hE, 8'h00);
        cpu_write(4'h9, 8'h06);
        chk("R11 pre req", 32'(swreq_o), 32'h4);
        pulse_eop(2);
        @(negedge clk);
        chk("R11 addr restored", 32'(caddr(2)), 32'h12AA);
        chk("R11 count restored", 32'(ccnt(2)), 32'h0005);
        chk("R11 mask kept", 32'(mask_o), 32'h0);
        chk("R11 req cleared", 32'(swreq_o), 32'h0);
        cpu_read(4'h8, d); chk("R9 tc ch2", 32'(d), 32'h04);
    endtask

    task automatic t_master_clear();
        logic [7:0] d;
        cpu_write(4'h8, 8'h04);
        cpu_write(4'h9, 8'h04);
        @(negedge clk); tmp_load = 1'b1; tmp_din = 8'h5A;
        @(negedge clk); tmp_load = 1'b0;
        cpu_read(4'hD, d); chk("R12 temp read", 32'(d), 32'h5A);
        cpu_write(4'h0, 8'h11);
        cpu_write(4'hD, 8'h00);
        chk("R12 cmd", 32'(cmd_o), 32'h0);
        chk("R12 mask", 32'(mask_o), 32'hF);
        chk("R12 req", 32'(swreq_o), 32'h0);
        chk("R12 mode kept", 32'(cmode(2)), 32'h15);
        chk("R12 chan kept", 32'(caddr(2)), 32'h12AA);
        cpu_read(4'hD, d); chk("R12 temp cleared", 32'(d), 32'h00);
        cpu_write(4'h0, 8'h22); cpu_write(4'h0, 8'h33);
        chk("R12 pointer cleared", 32'(caddr(0)), 32'h3322);
    endtask

    task automatic t_blocked();
        logic [7:0] d;
        @(negedge clk); tmp_load = 1'b1; tmp_din = 8'h3C;
        @(negedge clk); tmp_load = 1'b0; bus_grant = 1'b1;
        cpu_write(4'h8, 8'h04);
        chk("R13 cmd blocked", 32'(cmd_o), 32'h0);
        cpu_read(4'hD, d); chk("R13 read blocked", 32'(d), 32'h00);
        cpu_write(4'h0, 8'h99);
        @(negedge clk); bus_grant = 1'b0; cpu_sel = 1'b0;
        cpu_write(4'hB, 8'hFF);
        chk("R13 mode blocked", 32'(cmode(3)), 32'h00);
        cpu_write(4'h0, 8'h99);
        @(negedge clk); cpu_sel = 1'b1;
        cpu_write(4'h0, 8'h44); cpu_write(4'h0, 8'h55);
        chk("R13 pointer unmoved", 32'(caddr(0)), 32'h5544);
    endtask

    task automatic t_held();
        @(negedge clk); reg_addr = 4'h0; wdata = 8'h66; wr_stb = 1'b1;
        repeat (4) @(negedge clk);
        wr_stb = 1'b0;
        @(negedge clk);
        cpu_write(4'h0, 8'h77);
        chk("R14 single action", 32'(caddr(0)), 32'h7766);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_chan_rw();
        t_engine_update();
        t_ptr_clear();
        t_command();
        t_mode();
        t_req_mask();
        t_eop_plain();
        t_eop_auto();
        t_master_clear();
        t_blocked();
        t_held();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule